// File: doc/BRIEF.md
# Dual-Output Serial Flash Burst Reader

This block is the host side of a serial NOR flash read path. It takes a request made of a 24-bit start address and a nonzero byte count. It then runs one dual-output fast-read burst and delivers the bytes it receives on a valid/ready byte stream.

Each burst follows the same sequence. Chip-select goes low and a 40-clock header is shifted out on SIO0 alone: the read command, the address and one dummy byte. The controller then releases SIO0 and samples two bits per rising serial-clock edge, from SIO1 and SIO0, until the requested number of bytes has been collected. The flash advances its address by itself, so the bytes arrive in ascending address order.

The serial clock is derived from the system clock by a parameterised integer divider and idles low (SPI mode 0). When the byte consumer stalls, the controller stops the serial clock between bytes and keeps chip-select low. At the end of a burst, chip-select returns high for a minimum gap before another request is taken.

Top module: `dspi_burst_reader`

## Requirements
- R1: A request with a nonzero length is taken in a cycle where req_valid and req_ready are both high. Chip-select then falls, and the command byte 0x3B is presented MSB first on sio0_o for the first 8 rising edges of flash_sck (edges 0 to 7).
- R2: The 24-bit request address follows MSB first on sio0_o, on rising edges 8 to 31.
- R3: Rising edges 32 to 39 form the dummy byte. sio0_oe is high at every one of rising edges 0 to 39. It is low from the falling edge that ends edge 39 onwards, so it is never high while the flash drives data. sio0_oe is never high while chip-select is high.
- R4: Each received byte takes 4 rising edges, most significant pair first. On each edge, sio1_i carries one of bits 7, 5, 3, 1 and sio0_i carries one of bits 6, 4, 2, 0 of the byte.
- R5: A burst delivers exactly req_len bytes, in ascending address order with 24-bit wraparound, and runs exactly 40 + 4*req_len rising edges of flash_sck.
- R6: While out_valid is high and out_ready is low, out_data and out_valid hold their values. flash_sck stops before the rising edge that would complete the next byte, and chip-select stays low.
- R7: flash_sck is low whenever chip-select is high, and both are at their idle values (flash_sck low, flash_cs_n high) after reset.
- R8: After a burst, flash_cs_n stays high for at least GAP_SCK serial-clock periods before it falls again. req_ready is high only while chip-select is high.
- R9: A request with req_len equal to zero produces a one-cycle req_err pulse in the next cycle. It does not lower chip-select and does not raise busy.
- R10: busy rises in the cycle after a nonzero request is taken and falls in the cycle after done. done is a single-cycle pulse that coincides with the handshake of the last byte.
- R11: When it is not stalled, flash_sck has a period of 2*HALF_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | 24 | First byte address of the burst |
| req_len | input | LEN_W | Number of bytes to fetch |
| req_err | output | 1 | One-cycle pulse: zero-length request refused |
| busy | output | 1 | Burst in progress, from acceptance to done |
| done | output | 1 | One-cycle pulse on handshake of the final byte |
| out_valid | output | 1 | Received byte available |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Received byte |
| flash_cs_n | output | 1 | Flash chip-select, active low |
| flash_sck | output | 1 | Serial clock, idles low |
| sio0_o | output | 1 | Serial line 0 output value |
| sio0_oe | output | 1 | Serial line 0 output enable |
| sio0_i | input | 1 | Serial line 0 input (data bits 6,4,2,0) |
| sio1_i | input | 1 | Serial line 1 input (data bits 7,5,3,1) |

## Verification
The bench builds the block with HALF_DIV=2, GAP_SCK=2 and LEN_W=16. A short serial clock keeps each burst to a few hundred system cycles, so one run can cover single-byte bursts, a 33-byte burst, an address that wraps past 0xFFFFFF, back-to-back requests that hit the minimum chip-select gap, and a long consumer stall. A behavioural flash model in the bench decodes the header from the pins and drives data from an address-derived pattern. It also measures edge counts, clock period and gap length against these parameter values.

// File: rtl/dspi_pkg.sv
package dspi_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SEND,
    PH_DATA,
    PH_TAIL,
    PH_GAP
  } phase_e;

  localparam logic [7:0] DUAL_READ_CMD = 8'h3B;
  localparam int         HDR_BITS      = 40;
  localparam int         ADDR_BITS     = 24;
endpackage

// File: rtl/dspi_sck_gen.sv
module dspi_sck_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sck_q, sck_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF_DIV - 1));

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (run) begin
      if (wrap) begin
        cnt_d = '0;
        sck_d = ~sck_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck      = sck_q;
  assign rise_stb = run && wrap && !sck_q;
  assign fall_stb = run && wrap &&  sck_q;
endmodule

// File: rtl/dspi_tx_shift.sv
module dspi_tx_shift
  import dspi_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [ADDR_BITS-1:0] addr,
  input  logic                 shift,
  output logic                 sio0_o
);
  logic [HDR_BITS-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load)
      sr_d = {DUAL_READ_CMD, addr, 8'h00};
    else if (shift)
      sr_d = {sr_q[HDR_BITS-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign sio0_o = sr_q[HDR_BITS-1];
endmodule

// File: rtl/dspi_rx_stream.sv
module dspi_rx_stream (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       capture,
  input  logic       last_in,
  input  logic       sio1_i,
  input  logic       sio0_i,
  input  logic       out_ready,
  output logic       byte_edge,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       fin
);
  logic [1:0] pair_q, pair_d;
  logic [5:0] acc_q, acc_d;
  logic [7:0] data_q, data_d;
  logic       vld_q, vld_d;
  logic       last_q, last_d;

  assign byte_edge = (pair_q == 2'd3);

  always_comb begin
    pair_d = pair_q;
    acc_d  = acc_q;
    data_d = data_q;
    vld_d  = vld_q;
    last_d = last_q;
    if (vld_q && out_ready) vld_d = 1'b0;
    if (start) begin
      pair_d = 2'd0;
    end else if (capture) begin
      pair_d = pair_q + 2'd1;
      if (byte_edge) begin
        data_d = {acc_q, sio1_i, sio0_i};
        vld_d  = 1'b1;
        last_d = last_in;
      end else begin
        acc_d = {acc_q[3:0], sio1_i, sio0_i};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= 2'd0;
      acc_q  <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      pair_q <= pair_d;
      acc_q  <= acc_d;
      data_q <= data_d;
      vld_q  <= vld_d;
      last_q <= last_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;
  assign fin       = vld_q && out_ready && last_q;
endmodule

// File: rtl/dspi_burst_reader.sv
module dspi_burst_reader
  import dspi_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int LEN_W    = 16,
  parameter int GAP_SCK  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_err,
  output logic             busy,
  output logic             done,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             flash_cs_n,
  output logic             flash_sck,
  output logic             sio0_o,
  output logic             sio0_oe,
  input  logic             sio0_i,
  input  logic             sio1_i
);
  localparam int GAP_CYC  = 2 * HALF_DIV * GAP_SCK;
  localparam int GAP_W    = $clog2(GAP_CYC + 1);
  localparam int BIT_W    = $clog2(HDR_BITS + 1);

  logic             rst_meta_q, rst_sync_q, rst_i;
  phase_e           ph_q, ph_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             cs_n_q, cs_n_d;
  logic             oe_q, oe_d;
  logic             busy_q, busy_d;
  logic             err_q, err_d;

  logic             take, go, refuse;
  logic             run, stall, capture;
  logic             sck, rise_stb, fall_stb;
  logic             byte_edge, fin;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_i = rst_sync_q;

  assign req_ready = (ph_q == PH_IDLE);
  assign take      = req_valid && req_ready;
  assign go        = take && (req_len != '0);
  assign refuse    = take && (req_len == '0);

  assign stall   = (ph_q == PH_DATA) && byte_edge && !sck && out_valid && !out_ready;
  assign run     = (ph_q == PH_SEND) || (ph_q == PH_TAIL) || ((ph_q == PH_DATA) && !stall);
  assign capture = rise_stb && (ph_q == PH_DATA);

  always_comb begin
    ph_d   = ph_q;
    bit_d  = bit_q;
    left_d = left_q;
    gap_d  = gap_q;
    cs_n_d = cs_n_q;
    oe_d   = oe_q;
    busy_d = busy_q;
    err_d  = 1'b0;
    if (fin) busy_d = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (go) begin
          ph_d   = PH_SEND;
          cs_n_d = 1'b0;
          oe_d   = 1'b1;
          bit_d  = '0;
          left_d = req_len;
          busy_d = 1'b1;
        end
        if (refuse) err_d = 1'b1;
      end
      PH_SEND: begin
        if (rise_stb) bit_d = bit_q + 1'b1;
        if (fall_stb && bit_q == BIT_W'(HDR_BITS)) begin
          ph_d = PH_DATA;
          oe_d = 1'b0;
        end
      end
      PH_DATA: begin
        if (capture && byte_edge) begin
          left_d = left_q - 1'b1;
          if (left_q == LEN_W'(1)) ph_d = PH_TAIL;
        end
      end
      PH_TAIL: begin
        if (fall_stb) begin
          cs_n_d = 1'b1;
          gap_d  = '0;
          ph_d   = PH_GAP;
        end
      end
      PH_GAP: begin
        if (gap_q != GAP_W'(GAP_CYC - 1)) gap_d = gap_q + 1'b1;
        else if (!busy_q)                 ph_d  = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ph_q   <= PH_IDLE;
      bit_q  <= '0;
      left_q <= '0;
      gap_q  <= '0;
      cs_n_q <= 1'b1;
      oe_q   <= 1'b0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      left_q <= left_d;
      gap_q  <= gap_d;
      cs_n_q <= cs_n_d;
      oe_q   <= oe_d;
      busy_q <= busy_d;
      err_q  <= err_d;
    end
  end

  dspi_sck_gen #(.HALF_DIV(HALF_DIV)) i_sck (
    .clk      (clk),
    .rst_n    (rst_i),
    .run      (run),
    .sck      (sck),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  dspi_tx_shift i_tx (
    .clk    (clk),
    .rst_n  (rst_i),
    .load   (go),
    .addr   (req_addr),
    .shift  (fall_stb && (ph_q == PH_SEND)),
    .sio0_o (sio0_o)
  );

  dspi_rx_stream i_rx (
    .clk       (clk),
    .rst_n     (rst_i),
    .start     (go),
    .capture   (capture),
    .last_in   (left_q == LEN_W'(1)),
    .sio1_i    (sio1_i),
    .sio0_i    (sio0_i),
    .out_ready (out_ready),
    .byte_edge (byte_edge),
    .out_valid (out_valid),
    .out_data  (out_data),
    .fin       (fin)
  );

  assign flash_sck  = sck;
  assign flash_cs_n = cs_n_q;
  assign sio0_oe    = oe_q;
  assign busy       = busy_q;
  assign req_err    = err_q;
  assign done       = fin;
endmodule

// File: rtl/dspi_burst_reader_chk.sv
module dspi_burst_reader_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [23:0]      req_addr,
  input logic [LEN_W-1:0] req_len,
  input logic             req_err,
  input logic             busy,
  input logic             done,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             flash_cs_n,
  input logic             flash_sck,
  input logic             sio0_o,
  input logic             sio0_oe,
  input logic             sio0_i,
  input logic             sio1_i
);
  p_sck_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flash_cs_n |-> !flash_sck);

  p_oe_needs_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sio0_oe |-> !flash_cs_n);

  p_hold_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_done_clears_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_refuse_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (flash_cs_n && !busy));

  p_ready_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> flash_cs_n);

  p_start_selects_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_len != '0)) |=> (!flash_cs_n && busy));
endmodule

bind dspi_burst_reader dspi_burst_reader_chk #(.LEN_W(LEN_W)) i_chk (.*);

// File: tb/test_dspi_burst_reader.sv
`timescale 1ns/1ps
module test_dspi_burst_reader;
  localparam int HALF_DIV = 2;
  localparam int LEN_W    = 16;
  localparam int GAP_SCK  = 2;
  localparam real TCLK    = 5.0;

  logic             clk, rst_n;
  logic             req_valid, req_ready, req_err, busy, done;
  logic [23:0]      req_addr;
  logic [LEN_W-1:0] req_len;
  logic             out_valid, out_ready;
  logic [7:0]       out_data;
  logic             cs_n, sck, sio0_o, sio0_oe;
  logic             fsio0, fsio1;

  int n_chk, n_fail;
  int rdy_mode;
  int done_cnt;
  logic [7:0] exp_q[$];

  dspi_burst_reader #(.HALF_DIV(HALF_DIV), .LEN_W(LEN_W), .GAP_SCK(GAP_SCK)) i_dspi_burst_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_err(req_err), .busy(busy),
    .done(done), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .flash_cs_n(cs_n), .flash_sck(sck), .sio0_o(sio0_o), .sio0_oe(sio0_oe),
    .sio0_i(fsio0), .sio1_i(fsio1)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  function automatic logic [7:0] memf(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  int          m_rise, m_oe_bad, m_cs_bad, m_conf;
  logic [39:0] m_hdr;
  realtime     t_r0, t_r1, t_csr, gap_meas;

  initial begin
    fsio0 = 1'b0; fsio1 = 1'b0; m_rise = 0; m_oe_bad = 0; m_cs_bad = 0; m_conf = 0;
    m_hdr = '0; t_csr = -1.0; gap_meas = 1.0e9; t_r0 = 0; t_r1 = 0;
  end

  always @(negedge cs_n) begin
    m_rise = 0; m_oe_bad = 0; m_cs_bad = 0; m_conf = 0;
    if (t_csr >= 0) gap_meas = $realtime - t_csr;
  end
  always @(posedge cs_n) t_csr = $realtime;

  always @(posedge sck) begin
    if (cs_n) m_cs_bad++;
    if (m_rise == 0) t_r0 = $realtime;
    if (m_rise == 1) t_r1 = $realtime;
    if (m_rise < 40) begin
      m_hdr = {m_hdr[38:0], sio0_o};
      if (!sio0_oe) m_oe_bad++;
    end
    m_rise++;
  end

  always @(negedge sck) begin
    int k, p;
    logic [7:0] b;
    if (m_rise >= 40) begin
      k = m_rise - 40;
      p = k % 4;
      b = memf(m_hdr[31:8] + 24'(k / 4));
      fsio1 <= b[7 - 2*p];
      fsio0 <= b[6 - 2*p];
      #1;
      if (sio0_oe) m_conf++;
    end
  end

  // ---------------- consumer and monitor ----------------
  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = 1'($urandom % 2);
      default: out_ready = 1'b0;
    endcase
  end

  logic       pend_q;
  logic [7:0] pend_d;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_q) chk(out_valid && out_data == pend_d, "R6 hold", out_data, pend_d);
      pend_q = out_valid && !out_ready;
      pend_d = out_data;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 extra byte", out_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(out_data == e, "R4/R5 byte", out_data, e);
        end
      end
      if (done) done_cnt++;
    end else begin
      pend_q = 1'b0;
    end
  end

  // ---------------- driver ----------------
  task automatic issue(input logic [23:0] a, input int len);
    for (int i = 0; i < len; i++) exp_q.push_back(memf(a + 24'(i)));
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = a; req_len = LEN_W'(len);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic burst(input logic [23:0] a, input int len, input bit check_gap);
    int d0;
    d0 = done_cnt;
    issue(a, len);
    @(negedge clk);
    chk(busy == 1'b1 && cs_n == 1'b0, "R10 busy on start", busy, 1);
    while (done_cnt == d0) @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R10 busy after done", busy, 0);
    chk(done_cnt == d0 + 1, "R10 one done", done_cnt - d0, 1);
    chk(m_hdr[39:32] == 8'h3B, "R1 command", m_hdr[39:32], 8'h3B);
    chk(m_hdr[31:8] == a, "R2 address", m_hdr[31:8], a);
    chk(m_oe_bad == 0, "R3 oe in header", m_oe_bad, 0);
    chk(m_conf == 0, "R3 oe during data", m_conf, 0);
    chk(m_rise == 40 + 4*len, "R5 edge count", m_rise, 40 + 4*len);
    chk(m_cs_bad == 0, "R7 sck while deselected", m_cs_bad, 0);
    chk(exp_q.size() == 0, "R5 all bytes", exp_q.size(), 0);
    chk((t_r1 - t_r0) == 2*HALF_DIV*TCLK, "R11 sck period", longint'(t_r1 - t_r0), longint'(2*HALF_DIV*TCLK));
    if (check_gap)
      chk(gap_meas >= 2*GAP_SCK*HALF_DIV*TCLK, "R8 cs gap", longint'(gap_meas), longint'(2*GAP_SCK*HALF_DIV*TCLK));
  endtask

  bit finished;
  initial begin
    n_chk = 0; n_fail = 0; done_cnt = 0; rdy_mode = 0; finished = 0;
    req_valid = 1'b0; req_addr = '0; req_len = '0; out_ready = 1'b1;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && cs_n && !sck && !busy && !out_valid && !sio0_oe, "R7 reset state",
        {req_ready, cs_n, sck, busy, out_valid, sio0_oe}, 6'b110000);

    burst(24'h000100, 1, 0);
    rdy_mode = 1;
    burst(24'h0012F0, 16, 1);
    burst(24'hFFFFFE, 5, 1);
    rdy_mode = 0;
    burst(24'h123456, 3, 1);

    // R6: long consumer stall mid-burst
    begin
      int r0;
      logic [7:0] d0;
      rdy_mode = 2;
      issue(24'h000800, 6);
      while (!out_valid) @(negedge clk);
      repeat (40) @(negedge clk);
      r0 = m_rise; d0 = out_data;
      repeat (60) @(negedge clk);
      chk(m_rise == r0, "R6 sck paused", m_rise, r0);
      chk(!cs_n, "R6 cs held low", cs_n, 0);
      chk(out_valid && out_data == d0, "R6 byte held", out_data, d0);
      rdy_mode = 0;
      while (busy) @(negedge clk);
      chk(exp_q.size() == 0, "R6 no byte lost", exp_q.size(), 0);
      chk(m_rise == 40 + 4*6, "R5 edge count after stall", m_rise, 64);
    end

    // R9: zero-length request
    begin
      bit seen_err, bad;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      @(posedge clk); #1;
      req_valid = 1'b1; req_addr = 24'h00ABCD; req_len = '0;
      @(posedge clk); #1;
      req_valid = 1'b0;
      @(negedge clk);
      seen_err = req_err;
      chk(seen_err, "R9 err pulse", req_err, 1);
      bad = 1'b0;
      repeat (20) begin
        @(negedge clk);
        if (!cs_n || busy || req_err) bad = 1'b1;
      end
      chk(!bad, "R9 no transaction", bad, 0);
    end

    rdy_mode = 1;
    burst(24'h00ABCD, 33, 1);
    rdy_mode = 0;
    burst(24'h7FFFFF, 2, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule